// File: doc/BRIEF.md
# Fill-then-verify pattern memory tester

This block is a built-in self-test engine for a synchronous single-port SRAM with one cycle of read latency. A pulse on the start input launches three pattern tests in a fixed order. Each test first writes every location of the array in ascending address order. Only after the whole array holds the pattern does it read the array back, also in ascending order. A location is never read straight after its own write, so a floating data bus that still holds the last written value cannot make a missing or dead array look healthy.

The first two tests write alternating bit patterns that flip between neighbouring addresses, which exposes stuck data bits and coupling between adjacent cells. The third test writes a signature derived from the address: a seeded XOR fold of the address bytes. If an address line is open or shorted, two addresses map onto the same cell, and that cell then holds the signature of the wrong address. The expected value at each read is regenerated from the address, so no pattern is stored. The first mismatch stops the run and records its address together with the expected and actual data.

Top module: `mem_pattern_tester`

## Requirements
- R1: While rst_ni is low, and afterwards until the first start, done_o, fail_o, mem_we_o, mem_addr_o, mem_wdata_o and the three capture outputs are all zero.
- R2: Each test has a write phase followed by a read phase. The write phase drives mem_we_o high for 2**ADDR_W consecutive cycles with addresses 0, 1, 2 and so on up to the top address. The read phase follows at once, with mem_we_o low and mem_wdata_o zero, and issues the same addresses in the same order.
- R3: Test 0 (checkerboard) writes bytes of 0x55 to even addresses and bytes of 0xAA to odd addresses. For a data width of several bytes, the byte is repeated in every byte lane.
- R4: Test 1 (inverse checkerboard) writes bytes of 0xAA to even addresses and bytes of 0x55 to odd addresses, repeated in every byte lane.
- R5: Test 2 (address signature) writes, in every byte lane, 0xC3 XOR address[7:0] XOR address[15:8] XOR address[23:16]. Address bits above ADDR_W count as zero.
- R6: The tests run in the order 0, 1, 2. After the last read of a test there is exactly one idle cycle, with mem_we_o low and mem_addr_o zero. The next test's write phase starts in the cycle after that idle cycle.
- R7: The data returned for a read is sampled on mem_rdata_i in the cycle after the read address is presented, and it is compared against the pattern of that address for the current test.
- R8: At the first mismatch, done_o and fail_o rise at the next clock edge. fail_addr_o, fail_exp_o and fail_act_o then hold the mismatching address, its expected data and the data read back. From that point the memory port stays quiet: mem_we_o is low and mem_addr_o is zero.
- R9: If every compare matches, done_o rises with fail_o low exactly 3*(2*2**ADDR_W+1) cycles after the edge that accepted start_i.
- R10: While a run is in progress, start_i is ignored. Once done_o is high, it and the result outputs hold until start_i is asserted again. That start clears fail_o and launches a new run from test 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launches a run when idle or done |
| mem_addr_o | output | ADDR_W | SRAM address |
| mem_wdata_o | output | DATA_W | SRAM write data |
| mem_we_o | output | 1 | SRAM write enable (a read when low during a read phase) |
| mem_rdata_i | input | DATA_W | SRAM read data, valid one cycle after its address |
| done_o | output | 1 | Run finished |
| fail_o | output | 1 | Run stopped on a mismatch |
| fail_addr_o | output | ADDR_W | Address of the first mismatch |
| fail_exp_o | output | DATA_W | Expected data at that address |
| fail_act_o | output | DATA_W | Data read back at that address |

## Verification
The assertions take for granted that the memory answers every read with exactly one cycle of latency and never changes mem_rdata_i on its own between reads. They also take for granted that start_i is the only control input and that it may arrive at any time. The bench's memory model honours that latency on every read. Its injected faults (stuck data bits, open address lines, shorted address lines) only alter which cell is touched or which bits come back, never the timing. The bench also asserts start_i in the middle of a run and again once a run has finished.

// File: rtl/mpt_pkg.sv
package mpt_pkg;
  typedef enum logic [1:0] {
    TST_CHK = 2'd0,
    TST_INV = 2'd1,
    TST_ADR = 2'd2
  } test_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WR   = 3'd1,
    ST_RD   = 3'd2,
    ST_TAIL = 3'd3,
    ST_DONE = 3'd4
  } state_e;

  localparam logic [7:0] PAT_LO = 8'h55;
  localparam logic [7:0] PAT_HI = 8'hAA;
  localparam logic [7:0] SIG_SEED = 8'hC3;
endpackage

// File: rtl/mpt_addr_ctr.sv
module mpt_addr_ctr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_q <= '0;
    else if (clr_i) addr_q <= '0;
    else if (inc_i) addr_q <= addr_q + 1'b1; // wraps to 0 after the top address
  end

  assign addr_o = addr_q;
  assign last_o = &addr_q;
endmodule

// File: rtl/mpt_pattern.sv
module mpt_pattern
  import mpt_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  test_e             test_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] pat_o
);
  localparam int LANES  = DATA_W / 8;
  localparam int ABYTES = (ADDR_W + 7) / 8;
  localparam int APAD   = ABYTES * 8;

  logic [APAD-1:0] addr_pad;
  logic [7:0]      fold;
  logic [7:0]      lane_byte;

  assign addr_pad = APAD'(addr_i);

  always_comb begin
    fold = SIG_SEED;
    for (int i = 0; i < ABYTES; i++) fold = fold ^ addr_pad[8*i +: 8];
  end

  always_comb begin
    unique case (test_i)
      TST_CHK: lane_byte = addr_i[0] ? PAT_HI : PAT_LO;
      TST_INV: lane_byte = addr_i[0] ? PAT_LO : PAT_HI;
      default: lane_byte = fold;
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign pat_o[8*l +: 8] = lane_byte;
  end

  always_comb begin
    if (test_i != TST_ADR)
      AST_CHK_LANES_DIFFER: assert (pat_o != {LANES{8'h00}} && pat_o != {LANES{8'hFF}}); // R3
  end
endmodule

// File: rtl/mpt_cmp.sv
module mpt_cmp #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              chk_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              miss_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [DATA_W-1:0] fail_exp_o,
  output logic [DATA_W-1:0] fail_act_o
);
  logic              pend_vld_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_exp_q;
  logic              fail_q;
  logic [ADDR_W-1:0] cap_addr_q;
  logic [DATA_W-1:0] cap_exp_q, cap_act_q;

  // read data arrives one cycle after the address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_q  <= 1'b0;
      pend_addr_q <= '0;
      pend_exp_q  <= '0;
    end else begin
      pend_vld_q  <= chk_i && !clr_i;
      pend_addr_q <= addr_i;
      pend_exp_q  <= exp_i;
    end
  end

  assign miss_o = pend_vld_q && (rdata_i != pend_exp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q     <= 1'b0;
      cap_addr_q <= '0;
      cap_exp_q  <= '0;
      cap_act_q  <= '0;
    end else if (clr_i) begin
      fail_q     <= 1'b0;
      cap_addr_q <= '0;
      cap_exp_q  <= '0;
      cap_act_q  <= '0;
    end else if (miss_o && !fail_q) begin
      fail_q     <= 1'b1;
      cap_addr_q <= pend_addr_q;
      cap_exp_q  <= pend_exp_q;
      cap_act_q  <= rdata_i;
    end
  end

  assign fail_o      = fail_q;
  assign fail_addr_o = cap_addr_q;
  assign fail_exp_o  = cap_exp_q;
  assign fail_act_o  = cap_act_q;

  AST_CAPTURE_MISMATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> fail_exp_o != fail_act_o); // R8
  AST_CAPTURE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !clr_i |=> $stable(fail_addr_o) && $stable(fail_act_o)); // R8
endmodule

// File: rtl/mem_pattern_tester.sv
module mem_pattern_tester
  import mpt_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [DATA_W-1:0] fail_exp_o,
  output logic [DATA_W-1:0] fail_act_o
);
  state_e            st_q, st_d;
  test_e             tst_q, tst_d;
  logic              clr, inc, chk, miss, last;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] pat;

  mpt_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .inc_i (inc),
    .addr_o(addr),
    .last_o(last)
  );

  mpt_pattern #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pat (
    .test_i(tst_q),
    .addr_i(addr),
    .pat_o (pat)
  );

  mpt_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .chk_i      (chk),
    .addr_i     (addr),
    .exp_i      (pat),
    .rdata_i    (mem_rdata_i),
    .miss_o     (miss),
    .fail_o     (fail_o),
    .fail_addr_o(fail_addr_o),
    .fail_exp_o (fail_exp_o),
    .fail_act_o (fail_act_o)
  );

  always_comb begin
    st_d  = st_q;
    tst_d = tst_q;
    clr   = 1'b0;
    inc   = 1'b0;
    chk   = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          st_d  = ST_WR;
          tst_d = TST_CHK;
          clr   = 1'b1;
        end
      end
      ST_WR: begin
        inc = 1'b1;
        if (last) st_d = ST_RD;
      end
      ST_RD: begin
        inc = 1'b1;
        chk = 1'b1;
        if (miss)      st_d = ST_DONE;
        else if (last) st_d = ST_TAIL;
      end
      ST_TAIL: begin
        // the last read's data is compared here; no access overlaps it
        if (miss || tst_q == TST_ADR) st_d = ST_DONE;
        else begin
          st_d  = ST_WR;
          tst_d = (tst_q == TST_CHK) ? TST_INV : TST_ADR;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      tst_q <= TST_CHK;
    end else begin
      st_q  <= st_d;
      tst_q <= tst_d;
    end
  end

  assign mem_we_o    = (st_q == ST_WR);
  assign mem_addr_o  = (st_q == ST_WR || st_q == ST_RD) ? addr : '0;
  assign mem_wdata_o = (st_q == ST_WR) ? pat : '0;
  assign done_o      = (st_q == ST_DONE);

  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_we_o && mem_addr_o == '0); // R8
  AST_FAIL_MEANS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> done_o); // R8
  AST_WR_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && $past(mem_we_o) |-> mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1)); // R2
  AST_RD_FROM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_o && $past(mem_we_o) |-> mem_addr_o == '0 && !done_o); // R2
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && $stable(fail_o)); // R10
  AST_START_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && start_i |=> mem_we_o && mem_addr_o == '0 && !fail_o); // R10
endmodule

// File: tb/mem_pattern_tester_tb_top.sv
module mem_pattern_tester_tb_top;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam int N      = 1 << ADDR_W;

  localparam int F_NONE = 0, F_STK0 = 1, F_STK1 = 2, F_OPEN = 3, F_SHORT = 4;

  typedef struct {
    logic              we;
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] d;
    string             tag;
  } ent_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;
  logic              mem_we, done, fail;
  logic [ADDR_W-1:0] fail_addr;
  logic [DATA_W-1:0] fail_exp, fail_act;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  int fmode = F_NONE;
  int fbit  = 0;
  int faddr = 0;

  logic [DATA_W-1:0] ram [N];
  logic [DATA_W-1:0] shadow [N];
  ent_t              q[$];
  logic              x_fail;
  logic [ADDR_W-1:0] x_addr;
  logic [DATA_W-1:0] x_exp, x_act;

  always #10 clk = ~clk;

  mem_pattern_tester #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .mem_addr_o (mem_addr),
    .mem_wdata_o(mem_wdata),
    .mem_we_o   (mem_we),
    .mem_rdata_i(mem_rdata),
    .done_o     (done),
    .fail_o     (fail),
    .fail_addr_o(fail_addr),
    .fail_exp_o (fail_exp),
    .fail_act_o (fail_act)
  );

  function automatic logic [ADDR_W-1:0] phys(logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] p = a;
    if (fmode == F_OPEN) p[fbit] = 1'b0;
    if (fmode == F_SHORT) begin
      p[fbit]   = a[fbit] & a[fbit+1];
      p[fbit+1] = a[fbit] & a[fbit+1];
    end
    return p;
  endfunction

  function automatic logic [DATA_W-1:0] rd_fault(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r = d;
    if (fmode == F_STK0 && int'(a) == faddr) r[fbit] = 1'b0;
    if (fmode == F_STK1 && int'(a) == faddr) r[fbit] = 1'b1;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] exp_pat(int t, int a);
    logic [7:0]  b;
    logic [23:0] w = 24'(a);
    if (t == 0)      b = (a % 2 == 1) ? 8'hAA : 8'h55;
    else if (t == 1) b = (a % 2 == 1) ? 8'h55 : 8'hAA;
    else             b = 8'hC3 ^ w[7:0] ^ w[15:8] ^ w[23:16];
    return {(DATA_W/8){b}};
  endfunction

  // SRAM model: synchronous, one cycle read latency
  always @(posedge clk) begin
    if (mem_we) ram[phys(mem_addr)] <= mem_wdata;
    mem_rdata <= rd_fault(mem_addr, ram[phys(mem_addr)]);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 200000) begin
      n_err = n_err + 1;
      $display("FAIL watchdog: act cycles %0d exp below 200000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  task automatic check(input logic ok, input string msg);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_err = n_err + 1;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic build_expect();
    logic [DATA_W-1:0] got;
    q.delete();
    x_fail = 1'b0; x_addr = '0; x_exp = '0; x_act = '0;
    for (int t = 0; t < 3 && !x_fail; t++) begin
      string wtag = (t == 0) ? "R3" : (t == 1) ? "R4" : "R5";
      for (int a = 0; a < N; a++) begin
        q.push_back('{1'b1, ADDR_W'(a), exp_pat(t, a), wtag});
        shadow[phys(ADDR_W'(a))] = exp_pat(t, a);
      end
      for (int a = 0; a < N && !x_fail; a++) begin
        q.push_back('{1'b0, ADDR_W'(a), '0, "R2"});
        got = rd_fault(ADDR_W'(a), shadow[phys(ADDR_W'(a))]);
        if (got != exp_pat(t, a)) begin
          x_fail = 1'b1;
          x_addr = ADDR_W'(a);
          x_exp  = exp_pat(t, a);
          x_act  = got;
          if (a < N - 1) q.push_back('{1'b0, ADDR_W'(a + 1), '0, "R7"});
          else           q.push_back('{1'b0, '0, '0, "R7"});
        end
      end
      if (!x_fail) q.push_back('{1'b0, '0, '0, "R6"});
    end
  endtask

  task automatic run_case(input string name, input int mode, input int bt, input int ad,
                          input bit poke);
    int idx = 0;
    int len;
    fmode = mode; fbit = bt; faddr = ad;
    build_expect();
    len = q.size();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (q.size() > 0) begin
      ent_t e = q.pop_front();
      check(mem_we === e.we && mem_addr === e.a && mem_wdata === e.d && done === 1'b0,
            $sformatf("%s %s cycle %0d: act we/addr/wdata/done %0b/%0h/%0h/%0b exp %0b/%0h/%0h/0",
                      e.tag, name, idx, mem_we, mem_addr, mem_wdata, done, e.we, e.a, e.d));
      start = (poke && idx == 50) ? 1'b1 : 1'b0; // R10: ignored mid-run
      idx++;
      @(negedge clk);
    end
    start = 1'b0;
    if (!x_fail)
      check(len == 3 * (2 * N + 1),
            $sformatf("R9 %s run length: act %0d exp %0d", name, len, 3 * (2 * N + 1)));
    check(done === 1'b1 && fail === x_fail,
          $sformatf("%s %s end: act done/fail %0b/%0b exp 1/%0b", x_fail ? "R8" : "R9",
                    name, done, fail, x_fail));
    check(fail_addr === x_addr && fail_exp === x_exp && fail_act === x_act,
          $sformatf("R8 %s capture: act %0h/%0h/%0h exp %0h/%0h/%0h", name,
                    fail_addr, fail_exp, fail_act, x_addr, x_exp, x_act));
    repeat (3) @(negedge clk);
    check(done === 1'b1 && fail === x_fail && mem_we === 1'b0 && mem_addr === '0,
          $sformatf("R10 %s hold: act done/fail/we/addr %0b/%0b/%0b/%0h exp 1/%0b/0/0",
                    name, done, fail, mem_we, mem_addr, x_fail));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(done === 1'b0 && fail === 1'b0 && mem_we === 1'b0 && mem_addr === '0 &&
          mem_wdata === '0 && fail_addr === '0 && fail_exp === '0 && fail_act === '0,
          $sformatf("R1 in reset: act done/fail/we/addr %0b/%0b/%0b/%0h exp 0/0/0/0",
                    done, fail, mem_we, mem_addr));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done === 1'b0 && mem_we === 1'b0,
          $sformatf("R1 idle after reset: act done/we %0b/%0b exp 0/0", done, mem_we));
    run_case("clean", F_NONE, 0, 0, 1'b1);
    run_case("stuck0", F_STK0, 3, 5, 1'b0);
    run_case("stuck1", F_STK1, 0, 6, 1'b0);
    run_case("open_a4", F_OPEN, 4, 0, 1'b0);
    run_case("short_a8a9", F_SHORT, 8, 0, 1'b0);
    run_case("clean_again", F_NONE, 0, 0, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule